// File: doc/BRIEF.md
# Shadow Consistency Commit Sequencer

This block is a small bus master that runs once a partition's minimum or maximum bandwidth limit has been changed. A write to one of those limits is spread by the fabric into twelve per-slice shadow copies. These copies are read-only, and they do not all update at the same moment. The sequencer latches a 16-bit partition identifier when it is started. It then reads the twelve shadow copies for that partition over a simple request/response register bus. Slice 0 is read first and gives the reference value. Slices 1 to 11 are then read in ascending order and compared with that reference. A pass stops at the first slice that differs, and a new pass begins at slice 0.

The loop ends as soon as one pass finds all twelve copies equal, or when the retry budget of 1000 passes is used up. In both cases the block then writes 64-bit zero to the first commit register and afterwards to the second. Those two writes move the settled shadow values into the downstream limit registers. When the second write completes, the block gives a one-cycle done pulse and a per-run timeout flag. A sticky warning flag records that a timeout has happened at least once.

The bus carries one transaction at a time. A request is a single-cycle `req_valid_o` pulse. The block issues nothing further until it sees `rsp_valid_i`. The states are IDLE, RD_ISSUE, RD_WAIT, WR0_ISSUE, WR0_WAIT, WR1_ISSUE, WR1_WAIT and DONE. The transitions are:

- IDLE to RD_ISSUE on start.
- RD_ISSUE to RD_WAIT always.
- RD_WAIT to RD_ISSUE on a response when the next slice must be read or a retry begins.
- RD_WAIT to WR0_ISSUE on a response that completes a matching pass or ends the last permitted pass.
- WR0_ISSUE to WR0_WAIT always.
- WR0_WAIT to WR1_ISSUE on a response.
- WR1_ISSUE to WR1_WAIT always.
- WR1_WAIT to DONE on a response.
- DONE to IDLE always.

Top module: `shadow_commit_seq`

## Requirements
- R1: A start pulse is accepted only in IDLE, and `busy_o` rises on the next cycle. The partition identifier is captured at that moment. A start pulse or a change of `partid_i` while busy has no effect on any address of the run in progress.
- R2: Every shadow access is a read (`req_write_o`=0) to address 0x360048 + slice*0x10000 + partid*8, with the address taken as 32 bits. The block never writes to a shadow address.
- R3: Each pass reads slice 0 first, then slices 1, 2 and so on in ascending order. The first slice whose value differs from slice 0 ends the pass, and the next request is slice 0 of a new pass.
- R4: A pass in which all 12 values are equal ends the loop. No further shadow read follows it.
- R5: The loop runs at most 1000 passes. If the 1000th pass also fails, `timeout_o` is 1 when done is given. A run that ends with a matching pass shows `timeout_o`=0. `timeout_o` keeps its value until the next accepted start.
- R6: `warn_o` is set by the first run that times out. It stays at 1 through later runs, whether they match or not, and only reset clears it.
- R7: Whichever way the loop ends, exactly two writes follow it. The first carries data 0 to address 0x1b0000 and the second carries data 0 to address 0x1c0000.
- R8: `req_valid_o` is high for one cycle per transaction. No new request is issued until the response of the previous one has been seen.
- R9: `done_o` is high for exactly one cycle. That cycle directly follows the cycle in which the second write's response is seen. The block is idle (`busy_o`=0) on the cycle after done.
- R10: After reset, `req_valid_o`, `busy_o`, `done_o`, `timeout_o` and `warn_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, honoured only when idle |
| partid_i | input | 16 | Partition identifier, captured on start |
| req_valid_o | output | 1 | Single-cycle bus request strobe |
| req_write_o | output | 1 | 1 for write, 0 for read |
| req_addr_o | output | 32 | Request byte address |
| req_wdata_o | output | 64 | Write data (always zero) |
| rsp_valid_i | input | 1 | Response strobe for the outstanding request |
| rsp_rdata_i | input | 64 | Read data returned with the response |
| busy_o | output | 1 | Sequencer is not idle |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Last run exhausted its passes without agreement |
| warn_o | output | 1 | Sticky: some run has timed out since reset |

## Verification
The shadow model is driven in four patterns:
- All slices agree on the first pass. This gives exactly twelve reads and separates a correct loop exit from a retry that was not needed.
- One mid-range slice (slice 5) disagrees for two passes and then settles. This shows early exit at the first mismatch and a restart at slice 0.
- Slice 1 never agrees. This takes the loop to its 1000-pass limit and tells a correct retry bound from an off-by-one, and shows that the commit writes are still issued after a timeout.
- A matching run follows that timeout. This separates the per-run timeout flag from the sticky warning.

Further runs use the highest partition identifier, a long response latency, and a start pulse and identifier change while busy. These expose address arithmetic errors, requests that do not wait for their response, and inputs that leak into a run already in progress.

// File: rtl/shadow_commit_pkg.sv
package shadow_commit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ISSUE,
        ST_RD_WAIT,
        ST_WR0_ISSUE,
        ST_WR0_WAIT,
        ST_WR1_ISSUE,
        ST_WR1_WAIT,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        TGT_SHADOW,
        TGT_COMMIT_A,
        TGT_COMMIT_B
    } target_e;

    localparam int unsigned DEF_SHADOW_BASE  = 32'h0036_0048;
    localparam int unsigned DEF_SLICE_STRIDE = 32'h0001_0000;
    localparam int unsigned DEF_PID_STRIDE   = 8;
    localparam int unsigned DEF_COMMIT_A     = 32'h001b_0000;
    localparam int unsigned DEF_COMMIT_B     = 32'h001c_0000;

endpackage

// File: rtl/shadow_addr_gen.sv
module shadow_addr_gen
    import shadow_commit_pkg::*;
#(
    parameter int unsigned ADDR_W       = 32,
    parameter int unsigned PID_W        = 16,
    parameter int unsigned SLICE_W      = 4,
    parameter int unsigned SHADOW_BASE  = DEF_SHADOW_BASE,
    parameter int unsigned SLICE_STRIDE = DEF_SLICE_STRIDE,
    parameter int unsigned PID_STRIDE   = DEF_PID_STRIDE,
    parameter int unsigned COMMIT_A     = DEF_COMMIT_A,
    parameter int unsigned COMMIT_B     = DEF_COMMIT_B
) (
    input  target_e             target_i,
    input  logic [SLICE_W-1:0]  slice_i,
    input  logic [PID_W-1:0]    pid_i,
    output logic [ADDR_W-1:0]   addr_o
);
    logic [ADDR_W-1:0] slice_off;
    logic [ADDR_W-1:0] pid_off;

    always_comb begin
        slice_off = ADDR_W'(slice_i) * ADDR_W'(SLICE_STRIDE);
        pid_off   = ADDR_W'(pid_i) * ADDR_W'(PID_STRIDE);
    end

    always_comb begin
        unique case (target_i)
            TGT_COMMIT_A: addr_o = ADDR_W'(COMMIT_A);
            TGT_COMMIT_B: addr_o = ADDR_W'(COMMIT_B);
            default:      addr_o = ADDR_W'(SHADOW_BASE) + slice_off + pid_off;
        endcase
    end
endmodule

// File: rtl/slice_compare.sv
module slice_compare #(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              match_o
);
    logic [DATA_W-1:0] ref_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else if (capture_i) begin
            ref_q <= data_i;
        end
    end

    always_comb begin
        match_o = (data_i == ref_q);
    end
endmodule

// File: rtl/pass_counter.sv
module pass_counter #(
    parameter int unsigned MAX_PASSES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic last_o
);
    localparam int unsigned CNT_W = $clog2(MAX_PASSES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        last_o = (cnt_q == CNT_W'(MAX_PASSES - 1));
    end
endmodule

// File: rtl/shadow_commit_seq.sv
module shadow_commit_seq
    import shadow_commit_pkg::*;
#(
    parameter int unsigned NUM_SLICES   = 12,
    parameter int unsigned MAX_PASSES   = 1000,
    parameter int unsigned ADDR_W       = 32,
    parameter int unsigned DATA_W       = 64,
    parameter int unsigned PID_W        = 16,
    parameter int unsigned SHADOW_BASE  = DEF_SHADOW_BASE,
    parameter int unsigned SLICE_STRIDE = DEF_SLICE_STRIDE,
    parameter int unsigned PID_STRIDE   = DEF_PID_STRIDE,
    parameter int unsigned COMMIT_A     = DEF_COMMIT_A,
    parameter int unsigned COMMIT_B     = DEF_COMMIT_B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PID_W-1:0]  partid_i,
    output logic              req_valid_o,
    output logic              req_write_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [DATA_W-1:0] req_wdata_o,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o,
    output logic              warn_o
);
    localparam int unsigned SLICE_W    = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;
    localparam logic [SLICE_W-1:0] LAST_SLICE = SLICE_W'(NUM_SLICES - 1);

    seq_state_e         state_q, state_d;
    logic [SLICE_W-1:0] slice_q;
    logic [PID_W-1:0]   pid_q;
    logic               run_timeout_q;
    logic               timeout_q;
    logic               warn_q;
    target_e            target;

    logic accept;
    logic rd_rsp;
    logic ref_capture;
    logic values_equal;
    logic final_pass;
    logic miss;
    logic miss_retry;
    logic miss_give_up;
    logic pass_clean;
    logic advance_slice;

    // Datapath event decode
    always_comb begin
        accept        = (state_q == ST_IDLE) && start_i;
        rd_rsp        = (state_q == ST_RD_WAIT) && rsp_valid_i;
        ref_capture   = rd_rsp && (slice_q == '0);
        miss          = rd_rsp && (slice_q != '0) && !values_equal;
        miss_give_up  = miss && final_pass;
        miss_retry    = miss && !final_pass;
        pass_clean    = rd_rsp && (slice_q == LAST_SLICE) && (values_equal || (slice_q == '0));
        advance_slice = rd_rsp && !miss && (slice_q != LAST_SLICE);
    end

    slice_compare #(
        .DATA_W (DATA_W)
    ) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (ref_capture),
        .data_i    (rsp_rdata_i),
        .match_o   (values_equal)
    );

    pass_counter #(
        .MAX_PASSES (MAX_PASSES)
    ) u_passes (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .step_i  (miss),
        .last_o  (final_pass)
    );

    shadow_addr_gen #(
        .ADDR_W       (ADDR_W),
        .PID_W        (PID_W),
        .SLICE_W      (SLICE_W),
        .SHADOW_BASE  (SHADOW_BASE),
        .SLICE_STRIDE (SLICE_STRIDE),
        .PID_STRIDE   (PID_STRIDE),
        .COMMIT_A     (COMMIT_A),
        .COMMIT_B     (COMMIT_B)
    ) u_addr (
        .target_i (target),
        .slice_i  (slice_q),
        .pid_i    (pid_q),
        .addr_o   (req_addr_o)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_RD_ISSUE;
            ST_RD_ISSUE:  state_d = ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (pass_clean || miss_give_up) begin
                    state_d = ST_WR0_ISSUE;
                end else if (miss_retry || advance_slice) begin
                    state_d = ST_RD_ISSUE;
                end
            end
            ST_WR0_ISSUE: state_d = ST_WR0_WAIT;
            ST_WR0_WAIT:  if (rsp_valid_i) state_d = ST_WR1_ISSUE;
            ST_WR1_ISSUE: state_d = ST_WR1_WAIT;
            ST_WR1_WAIT:  if (rsp_valid_i) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register and run context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            slice_q       <= '0;
            pid_q         <= '0;
            run_timeout_q <= 1'b0;
            timeout_q     <= 1'b0;
            warn_q        <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                pid_q         <= partid_i;
                slice_q       <= '0;
                run_timeout_q <= 1'b0;
                timeout_q     <= 1'b0;
            end else if (miss_retry) begin
                slice_q <= '0;
            end else if (advance_slice) begin
                slice_q <= slice_q + SLICE_W'(1);
            end
            if (miss_give_up) begin
                run_timeout_q <= 1'b1;
            end
            if (state_d == ST_DONE && state_q != ST_DONE) begin
                timeout_q <= run_timeout_q;
                warn_q    <= warn_q | run_timeout_q;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        req_valid_o = 1'b0;
        req_write_o = 1'b0;
        target      = TGT_SHADOW;
        done_o      = 1'b0;
        busy_o      = 1'b1;
        unique case (state_q)
            ST_IDLE:      busy_o = 1'b0;
            ST_RD_ISSUE:  req_valid_o = 1'b1;
            ST_RD_WAIT:   target = TGT_SHADOW;
            ST_WR0_ISSUE: begin
                req_valid_o = 1'b1;
                req_write_o = 1'b1;
                target      = TGT_COMMIT_A;
            end
            ST_WR0_WAIT:  target = TGT_COMMIT_A;
            ST_WR1_ISSUE: begin
                req_valid_o = 1'b1;
                req_write_o = 1'b1;
                target      = TGT_COMMIT_B;
            end
            ST_WR1_WAIT:  target = TGT_COMMIT_B;
            ST_DONE:      done_o = 1'b1;
            default:      busy_o = 1'b0;
        endcase
        req_wdata_o = '0;
        timeout_o   = timeout_q;
        warn_o      = warn_q;
    end
endmodule

// File: rtl/shadow_commit_chk.sv
module shadow_commit_chk #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned SHADOW_BASE = 32'h0036_0048,
    parameter int unsigned COMMIT_A = 32'h001b_0000,
    parameter int unsigned COMMIT_B = 32'h001c_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              req_valid_o,
    input logic              req_write_o,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic [DATA_W-1:0] req_wdata_o,
    input logic              rsp_valid_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              timeout_o,
    input logic              warn_o
);
    logic pending_q;
    logic saw_a_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            saw_a_q   <= 1'b0;
        end else begin
            if (req_valid_o) pending_q <= 1'b1;
            else if (rsp_valid_i) pending_q <= 1'b0;
            if (req_valid_o && req_write_o && req_addr_o == ADDR_W'(COMMIT_A)) saw_a_q <= 1'b1;
            else if (done_o) saw_a_q <= 1'b0;
        end
    end

    assert_req_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |=> !req_valid_o);

    assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && !rsp_valid_i) |-> !req_valid_o);

    assert_writes_commit_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_write_o) |->
            ((req_addr_o == ADDR_W'(COMMIT_A) || req_addr_o == ADDR_W'(COMMIT_B)) && req_wdata_o == '0));

    assert_read_in_shadow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_write_o) |-> (req_addr_o >= ADDR_W'(SHADOW_BASE)));

    assert_commit_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_write_o && req_addr_o == ADDR_W'(COMMIT_B)) |-> saw_a_q);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    assert_start_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    assert_timeout_at_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> done_o);

    assert_warn_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        warn_o |=> warn_o);
endmodule

bind shadow_commit_seq shadow_commit_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .SHADOW_BASE (SHADOW_BASE),
    .COMMIT_A    (COMMIT_A),
    .COMMIT_B    (COMMIT_B)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .req_valid_o (req_valid_o),
    .req_write_o (req_write_o),
    .req_addr_o  (req_addr_o),
    .req_wdata_o (req_wdata_o),
    .rsp_valid_i (rsp_valid_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .timeout_o   (timeout_o),
    .warn_o      (warn_o)
);

// File: tb/sim_shadow_commit_seq.sv
`timescale 1ns/1ps
module sim_shadow_commit_seq;
    localparam int NSL = 12;
    localparam int MAXP = 1000;
    localparam logic [31:0] BASE = 32'h0036_0048;
    localparam logic [31:0] CA = 32'h001b_0000;
    localparam logic [31:0] CB = 32'h001c_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] partid_i = '0;
    logic        req_valid_o, req_write_o;
    logic [31:0] req_addr_o;
    logic [63:0] req_wdata_o;
    logic        rsp_valid_i = 1'b0;
    logic [63:0] rsp_rdata_i = '0;
    logic        busy_o, done_o, timeout_o, warn_o;

    always #2 clk = ~clk;

    shadow_commit_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .partid_i(partid_i),
        .req_valid_o(req_valid_o), .req_write_o(req_write_o), .req_addr_o(req_addr_o),
        .req_wdata_o(req_wdata_o), .rsp_valid_i(rsp_valid_i), .rsp_rdata_i(rsp_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o), .warn_o(warn_o)
    );

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    // Transaction log and shadow model
    logic [31:0] log_addr [0:4095];
    logic        log_wr   [0:4095];
    logic [63:0] log_data [0:4095];
    int n_txn = 0;
    int lat = 1;
    int bad_slice = 0;
    int settle = 0;
    int pass_seen = 0;
    int pend = 0;
    bit awaiting = 0;
    logic [63:0] pend_data = '0;
    int overlap_err = 0;
    int done_cnt = 0;
    int done_txn = 0;
    int done_long = 0;
    bit prev_done = 0;
    int idle_after_done_err = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, what, act, act, exp, exp);
        end
    endtask

    function automatic logic [63:0] shadow_val(input int sl);
        logic [63:0] v;
        v = 64'hA5A5_0000_1234_5678;
        if (sl == bad_slice && bad_slice != 0 && (pass_seen - 1) < settle) v = v ^ 64'h1;
        return v;
    endfunction

    // Responder and monitor, all at negedge
    initial begin
        forever begin
            @(negedge clk);
            cycles++;
            if (prev_done && busy_o) idle_after_done_err++;
            if (done_o) begin
                if (prev_done) done_long++;
                done_cnt++;
                done_txn = n_txn;
            end
            prev_done = done_o;
            if (rsp_valid_i) begin
                rsp_valid_i = 1'b0;
                awaiting = 0;
            end
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    rsp_valid_i = 1'b1;
                    rsp_rdata_i = pend_data;
                end
            end
            if (req_valid_o) begin
                int sl;
                if (awaiting) overlap_err++;
                awaiting = 1;
                if (n_txn < 4096) begin
                    log_addr[n_txn] = req_addr_o;
                    log_wr[n_txn]   = req_write_o;
                    log_data[n_txn] = req_wdata_o;
                end
                n_txn++;
                sl = int'((req_addr_o - BASE) >> 16);
                if (!req_write_o && sl == 0) pass_seen++;
                pend_data = req_write_o ? 64'h0 : shadow_val(sl);
                pend = lat;
            end
        end
    end

    // Watchdog
    initial begin
        wait (cycles > 150000);
        chk(1'b0, "WDOG", "watchdog expired", cycles, 150000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    task automatic pulse_start(input logic [15:0] pid);
        @(negedge clk);
        partid_i = pid;
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
    endtask

    // Launch a run; optionally poke start and partid mid-run
    task automatic run(input logic [15:0] pid, input int bsl, input int stl,
                       input int l, input bit poke);
        int d0;
        bad_slice = bsl; settle = stl; lat = l;
        pass_seen = 0; n_txn = 0; overlap_err = 0;
        d0 = done_cnt;
        pulse_start(pid);
        chk(busy_o == 1'b1, "R1", "busy after start", busy_o, 1);
        if (poke) begin
            repeat (7) @(negedge clk);
            partid_i = ~pid;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (done_cnt == d0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    // Check the whole transaction sequence for one run
    task automatic check_seq(input logic [15:0] pid, input int bsl, input int stl, input string tag);
        int fails, idx, exp_n, errs;
        fails = (bsl == 0) ? 0 : ((stl < MAXP) ? stl : MAXP);
        exp_n = fails * (bsl + 1) + ((fails < MAXP) ? NSL : 0) + 2;
        chk(done_txn == exp_n, tag, "transactions before done (R3/R4/R5/R9)", done_txn, exp_n);
        chk(n_txn == exp_n, tag, "no transaction after done (R4)", n_txn, exp_n);
        errs = 0; idx = 0;
        for (int p = 0; p < fails; p++) begin
            for (int s = 0; s <= bsl; s++) begin
                if (log_wr[idx] || log_addr[idx] != BASE + 32'(s) * 32'h10000 + 32'(pid) * 8) errs++;
                idx++;
            end
        end
        if (fails < MAXP) begin
            for (int s = 0; s < NSL; s++) begin
                if (log_wr[idx] || log_addr[idx] != BASE + 32'(s) * 32'h10000 + 32'(pid) * 8) errs++;
                idx++;
            end
        end
        chk(errs == 0, "R2", {tag, " read addresses and order (R3)"}, errs, 0);
        chk(log_wr[idx] && log_addr[idx] == CA && log_data[idx] == 0, "R7",
            {tag, " first commit write"}, log_addr[idx], CA);
        chk(log_wr[idx+1] && log_addr[idx+1] == CB && log_data[idx+1] == 0, "R7",
            {tag, " second commit write"}, log_addr[idx+1], CB);
        chk(overlap_err == 0, "R8", {tag, " request while outstanding"}, overlap_err, 0);
    endtask

    task automatic t_reset;
        chk(req_valid_o == 0, "R10", "reset req_valid", req_valid_o, 0);
        chk(busy_o == 0, "R10", "reset busy", busy_o, 0);
        chk(done_o == 0, "R10", "reset done", done_o, 0);
        chk(timeout_o == 0 && warn_o == 0, "R10", "reset flags", {timeout_o, warn_o}, 0);
    endtask

    task automatic t_all_agree;
        run(16'h0003, 0, 0, 1, 0);
        check_seq(16'h0003, 0, 0, "R4");
        chk(timeout_o == 0, "R5", "clean run timeout", timeout_o, 0);
        chk(warn_o == 0, "R6", "clean run warn", warn_o, 0);
    endtask

    task automatic t_settle_later;
        run(16'h0021, 5, 2, 2, 0);
        check_seq(16'h0021, 5, 2, "R3");
        chk(timeout_o == 0, "R5", "settled run timeout", timeout_o, 0);
    endtask

    task automatic t_never_agree;
        run(16'h0100, 1, 100000, 1, 0);
        check_seq(16'h0100, 1, 100000, "R5");
        chk(timeout_o == 1, "R5", "timeout after pass limit", timeout_o, 1);
        chk(warn_o == 1, "R6", "warn after timeout", warn_o, 1);
    endtask

    task automatic t_after_timeout;
        run(16'hFFFF, 0, 0, 4, 0);
        check_seq(16'hFFFF, 0, 0, "R2");
        chk(timeout_o == 0, "R5", "timeout cleared by next run", timeout_o, 0);
        chk(warn_o == 1, "R6", "warn stays set", warn_o, 1);
    endtask

    task automatic t_busy_start;
        run(16'h0042, 11, 1, 1, 1);
        check_seq(16'h0042, 11, 1, "R1");
        chk(done_long == 0, "R9", "done width", done_long, 0);
        chk(idle_after_done_err == 0, "R9", "idle after done", idle_after_done_err, 0);
        chk(done_cnt == 5, "R9", "done pulse count", done_cnt, 5);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_all_agree();
        t_settle_later();
        t_never_agree();
        t_after_timeout();
        t_busy_start();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule